// File: doc/BRIEF.md
# Two-Wire Memory Slave Controller

This block is a slave on a two-wire serial bus that fronts a 256-byte storage array. A master writes one byte, or a burst of up to eight bytes that stays inside one aligned 8-byte page. It reads back from the current location, from an address it has just loaded, or as a run of bytes that continues for as long as the master keeps acknowledging. Bus lines are brought into the system clock domain through two-flop synchronisers. Start, stop and clock edges are then detected there. SDA is driven only as an open-drain pull-down enable.

A completed write is held in a page buffer and is committed only when a stop condition ends the transfer. The commit starts a timed internal write cycle of `WR_CYCLES` system clocks. While that cycle runs the block does not answer its device address, so a master can poll with address bytes until it gets an acknowledge. A write-protect input turns write transfers into acknowledged no-ops. Three locations at the top of the map drive wiper setting outputs directly.

Top module: `twm_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `busy_o` are low, every wiper output is zero, and every storage byte reads as 00h.
- R2: The device address byte, sent MSB first, is 1,0,1,0,0,0, then the `a0_i` level, then the direction bit (1 = read). The block acknowledges only that pattern. A byte with another prefix or the opposite A0 bit is not acknowledged.
- R3: The block pulls SDA low for the whole ninth clock after every accepted device-address, memory-address and write-data byte. It changes `sda_oe_o` only while SCL is low.
- R4: A write of device address, memory address, one data byte and stop stores that byte at that address.
- R5: Successive write-data bytes go to successive addresses. After offset 7 of the 8-byte page (address bits 2:0), they continue at offset 0 of the same page. Bytes of other pages are untouched.
- R6: Buffered write data is stored, and the internal write cycle starts, only on a stop condition. A write ended by a repeated start stores nothing. A write with no data byte stores nothing and starts no cycle.
- R7: A stored write raises `busy_o` for exactly `WR_CYCLES` clocks. While `busy_o` is high the device address is not acknowledged. After it falls the address is acknowledged again.
- R8: An address pointer holds the last accessed location plus one, and a read with no preceding memory address returns the byte at it. For writes the increment wraps within the page. For reads it wraps from FFh to 00h.
- R9: A memory-address write without data, then a repeated start and a read, returns the byte at the loaded address.
- R10: During a read the block sends another byte after each byte the master acknowledges (SDA low on the ninth clock). It stops driving after a byte the master does not acknowledge.
- R11: With `wp_i` high at the stop condition, all bytes are still acknowledged, but nothing is stored and `busy_o` stays low.
- R12: `wiper_a_o` equals the byte at F8h. `wiper_b_o` and `wiper_c_o` equal bits 6:0 of the bytes at F9h and FAh, so a written MSB has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| a0_i | input | 1 | Strapped device address bit |
| wp_i | input | 1 | Write protect, high blocks storage |
| sda_oe_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | Internal write cycle running |
| wiper_a_o | output | 8 | Wiper setting from F8h |
| wiper_b_o | output | 7 | Wiper setting from F9h bits 6:0 |
| wiper_c_o | output | 7 | Wiper setting from FAh bits 6:0 |

## Verification
Two functions can land in the same cycle: the end of the internal write cycle and the decoding of a device address. The decode must read the busy state of that very cycle. The bench provokes this by polling with address-only transfers straight after a committed write, with the cycle length chosen to span more than one address byte. It judges that at least one poll is refused, that a poll is later accepted, and that the stored byte reads back. A bound property separately forbids any address acceptance in a cycle where the write timer is running.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_MADDR,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RACK
  } twm_st_e;

  localparam logic [5:0] DEV_PREFIX = 6'b101000;
endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twm_store.sv
module twm_store #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 300
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]          page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0]       data_i,
  input  logic [(1<<PAGE_W)-1:0]            mask_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [7:0]                        rd_data_o,
  output logic                              busy_o,
  output logic [7:0]                        wiper_a_o,
  output logic [7:0]                        wiper_b_o,
  output logic [7:0]                        wiper_c_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE       = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);
  localparam int WIPER_BASE = DEPTH - 8;

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] tmr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int k = 0; k < PAGE; k++) begin
        if (mask_i[k]) mem_q[{page_i, PAGE_W'(k)}] <= data_i[k];
      end
    end
  end

  always_comb begin
    tmr_d = tmr_q;
    if (commit_i)          tmr_d = CNT_W'(WR_CYCLES);
    else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign busy_o    = (tmr_q != '0);
  assign rd_data_o = mem_q[rd_addr_i];
  assign wiper_a_o = mem_q[WIPER_BASE];
  assign wiper_b_o = mem_q[WIPER_BASE+1];
  assign wiper_c_o = mem_q[WIPER_BASE+2];
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter int WR_CYCLES   = 300,
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       a0_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic [7:0] wiper_a_o,
  output logic [6:0] wiper_b_o,
  output logic [6:0] wiper_c_o
);
  import twm_pkg::*;

  localparam int ADDR_W = 8;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ns = rst_sh[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_st_e                  st_q, st_d, nxt_q, nxt_d;
  logic [3:0]               cnt_q, cnt_d;
  logic [7:0]               sh_q, sh_d;
  logic [ADDR_W-1:0]        ptr_q, ptr_d;
  logic [PG_W-1:0]          pg_q, pg_d;
  logic [PAGE-1:0][7:0]     wbuf_q, wbuf_d;
  logic [PAGE-1:0]          mask_q, mask_d;
  logic                     sda_oe_q, sda_oe_d;
  logic                     rack_q, rack_d;
  logic                     dev_acc;
  logic                     mem_commit;
  logic [PAGE_W-1:0]        idx;
  logic [7:0]               rd_data;
  logic [7:0]               wa, wb, wc;

  twm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk       (clk),
    .rst_n     (rst_ns),
    .commit_i  (mem_commit),
    .page_i    (pg_q),
    .data_i    (wbuf_q),
    .mask_i    (mask_q),
    .rd_addr_i (ptr_q),
    .rd_data_o (rd_data),
    .busy_o    (busy_o),
    .wiper_a_o (wa),
    .wiper_b_o (wb),
    .wiper_c_o (wc)
  );

  assign idx = ptr_q[PAGE_W-1:0];

  always_comb begin
    st_d       = st_q;
    nxt_d      = nxt_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    ptr_d      = ptr_q;
    pg_d       = pg_q;
    wbuf_d     = wbuf_q;
    mask_d     = mask_q;
    sda_oe_d   = sda_oe_q;
    rack_d     = rack_q;
    dev_acc    = 1'b0;
    mem_commit = 1'b0;

    if (start_det) begin
      st_d     = ST_DEV;
      cnt_d    = '0;
      mask_d   = '0;
      sda_oe_d = 1'b0;
    end else if (stop_det) begin
      st_d     = ST_IDLE;
      sda_oe_d = 1'b0;
      mask_d   = '0;
      if ((mask_q != '0) && !wp_i && !busy_o) mem_commit = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_DEV, ST_MADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (st_q == ST_DEV) begin
              if (sh_q[7:2] == DEV_PREFIX && sh_q[1] == a0_i && !busy_o) begin
                dev_acc  = 1'b1;
                sda_oe_d = 1'b1;
                st_d     = ST_ACK;
                nxt_d    = sh_q[0] ? ST_RD : ST_MADDR;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_MADDR) begin
              ptr_d    = sh_q;
              pg_d     = sh_q[7:PAGE_W];
              sda_oe_d = 1'b1;
              st_d     = ST_ACK;
              nxt_d    = ST_WDATA;
            end else begin
              wbuf_d[idx] = sh_q;
              mask_d[idx] = 1'b1;
              ptr_d       = {pg_q, idx + {{(PAGE_W-1){1'b0}}, 1'b1}};
              sda_oe_d    = 1'b1;
              st_d        = ST_ACK;
              nxt_d       = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (nxt_q == ST_RD) begin
              sda_oe_d = ~rd_data[7];
              sh_d     = {rd_data[6:0], 1'b0};
              ptr_d    = ptr_q + 1'b1;
            end else begin
              sda_oe_d = 1'b0;
            end
            st_d = nxt_q;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              sda_oe_d = 1'b0;
              st_d     = ST_RACK;
            end else begin
              sda_oe_d = ~sh_q[7];
              sh_d     = {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            rack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (rack_q) begin
              sda_oe_d = ~rd_data[7];
              sh_d     = {rd_data[6:0], 1'b0};
              ptr_d    = ptr_q + 1'b1;
              cnt_d    = '0;
              st_d     = ST_RD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q     <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      pg_q     <= '0;
      wbuf_q   <= '0;
      mask_q   <= '0;
      sda_oe_q <= 1'b0;
      rack_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      nxt_q    <= nxt_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      ptr_q    <= ptr_d;
      pg_q     <= pg_d;
      wbuf_q   <= wbuf_d;
      mask_q   <= mask_d;
      sda_oe_q <= sda_oe_d;
      rack_q   <= rack_d;
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wiper_a_o = wa;
  assign wiper_b_o = wb[6:0];
  assign wiper_c_o = wc[6:0];
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk #(
  parameter int WR_CYCLES = 300
) (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic sda_oe,
  input logic busy_o,
  input logic dev_acc,
  input logic stop_det,
  input logic wp_i
);
  logic [31:0] blen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blen_q <= '0;
    else if (busy_o) blen_q <= blen_q + 1;
    else             blen_q <= '0;
  end

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R7
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_acc |-> !busy_o);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> blen_q == 32'(WR_CYCLES));

  // R6
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det));

  // R11
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(wp_i));
endmodule

bind twm_slave twm_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .scl_lvl  (scl_lvl),
  .sda_oe   (sda_oe_o),
  .busy_o   (busy_o),
  .dev_acc  (dev_acc),
  .stop_det (stop_det),
  .wp_i     (wp_i)
);

// File: tb/twm_slave_bench.sv
module twm_slave_bench;
  localparam int WR = 300;
  localparam int Q  = 10;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       a0;
  logic       wp;
  logic       sda_oe;
  logic       busy;
  logic [7:0] wa;
  logic [6:0] wb, wc;
  logic       sda_line;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  assign sda_line = sda_m & ~sda_oe;

  twm_slave #(.WR_CYCLES(WR)) u_twm_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .a0_i      (a0),
    .wp_i      (wp),
    .sda_oe_o  (sda_oe),
    .busy_o    (busy),
    .wiper_a_o (wa),
    .wiper_b_o (wb),
    .wiper_c_o (wc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q/2);
    ack = ~sda_line;
    hold(Q - Q/2);
    scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q/2);
      b[i] = sda_line;
      hold(Q - Q/2);
      scl_m = 1'b0;
    end
    sda_m = ~mack; hold(Q);
    scl_m = 1'b1; hold(Q);
    scl_m = 1'b0;
  endtask

  // bytes are packed with the first byte in bits 7:0
  task automatic wr_bytes(input logic [7:0] addr, input int n, input logic [63:0] data,
                          output int nacks);
    bit ack;
    nacks = 0;
    bus_start();
    wbyte(8'hA2, ack); if (!ack) nacks++;
    wbyte(addr, ack);  if (!ack) nacks++;
    for (int i = 0; i < n; i++) begin
      wbyte(data[8*i +: 8], ack); if (!ack) nacks++;
    end
    bus_stop();
  endtask

  task automatic rd_rand(input logic [7:0] addr, input int n, output logic [63:0] got);
    bit ack;
    logic [7:0] b;
    got = '0;
    bus_start();
    wbyte(8'hA2, ack);
    wbyte(addr, ack);
    bus_start();
    wbyte(8'hA3, ack);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      got[8*i +: 8] = b;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", 64'(sda_oe), 0);
    chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
    chk({wa, wb, wc} == '0, "R1 wipers", 64'({wa, wb, wc}), 0);
  endtask

  task automatic t_addr();
    bit ack;
    bus_start(); wbyte(8'hA0, ack); bus_stop();
    chk(!ack, "R2 wrong A0 bit", 64'(ack), 0);
    bus_start(); wbyte(8'hB2, ack); bus_stop();
    chk(!ack, "R2 wrong prefix", 64'(ack), 0);
    bus_start(); wbyte(8'hA2, ack);
    chk(ack, "R2 matching address", 64'(ack), 1);
    wbyte(8'h05, ack);
    chk(ack, "R3 memory address ack", 64'(ack), 1);
    bus_stop(); hold(3);
    chk(!busy, "R6 no data no cycle", 64'(busy), 0);
  endtask

  task automatic t_single_poll();
    int nk, refused, polls;
    bit ack, acked, ack_busy;
    logic [63:0] got;
    wr_bytes(8'h10, 1, 64'h5A, nk);
    chk(nk == 0, "R3 single write acks", 64'(nk), 0);
    chk(busy, "R7 busy after stop", 64'(busy), 1);
    refused = 0; polls = 0; acked = 0; ack_busy = 0;
    while (!acked && polls < 20) begin
      bus_start(); wbyte(8'hA2, ack);
      if (ack) begin acked = 1; ack_busy = busy; end
      else refused++;
      bus_stop();
      polls++;
    end
    chk(refused >= 1, "R7 poll refused while busy", 64'(refused), 1);
    chk(acked && !ack_busy, "R7 poll accepted after cycle", 64'({acked, ack_busy}), 2);
    rd_rand(8'h10, 1, got);
    chk(got[7:0] == 8'h5A, "R4 R9 readback", got, 64'h5A);
  endtask

  task automatic t_page();
    int nk;
    logic [63:0] got;
    wr_bytes(8'h2E, 4, 64'h44332211, nk);
    hold(WR + 20);
    chk(nk == 0, "R3 page acks", 64'(nk), 0);
    rd_rand(8'h2E, 2, got);
    chk(got[15:0] == 16'h2211, "R5 page head", got, 64'h2211);
    rd_rand(8'h28, 2, got);
    chk(got[15:0] == 16'h4433, "R5 page wrap", got, 64'h4433);
    rd_rand(8'h30, 1, got);
    chk(got[7:0] == 8'h00, "R5 next page untouched", got, 0);
  endtask

  task automatic t_current();
    logic [63:0] got;
    logic [7:0] b;
    bit ack;
    rd_rand(8'h2E, 1, got);
    bus_start(); wbyte(8'hA3, ack); rbyte(1'b0, b); bus_stop();
    chk(b == 8'h22, "R8 current address read", 64'(b), 64'h22);
  endtask

  task automatic t_abort();
    bit ack;
    logic [7:0] b;
    logic [63:0] got;
    bus_start();
    wbyte(8'hA2, ack); wbyte(8'h40, ack); wbyte(8'h77, ack);
    bus_start();
    wbyte(8'hA3, ack); rbyte(1'b0, b);
    bus_stop(); hold(3);
    chk(!busy, "R6 aborted write no cycle", 64'(busy), 0);
    rd_rand(8'h40, 1, got);
    chk(got[7:0] == 8'h00, "R6 aborted write not stored", got, 0);
  endtask

  task automatic t_wrap();
    int nk;
    logic [63:0] got;
    wr_bytes(8'h00, 1, 64'h3C, nk); hold(WR + 20);
    wr_bytes(8'hFF, 1, 64'hC3, nk); hold(WR + 20);
    rd_rand(8'hFF, 2, got);
    chk(got[15:0] == 16'h3CC3, "R10 R8 sequential wrap FFh to 00h", got, 64'h3CC3);
  endtask

  task automatic t_protect();
    int nk;
    logic [63:0] got;
    wp = 1'b1;
    wr_bytes(8'h50, 2, 64'hBB99, nk);
    hold(3);
    chk(nk == 0, "R11 protected bytes acked", 64'(nk), 0);
    chk(!busy, "R11 no cycle under protect", 64'(busy), 0);
    wp = 1'b0;
    rd_rand(8'h50, 2, got);
    chk(got[15:0] == 16'h0000, "R11 nothing stored", got, 0);
  endtask

  task automatic t_wiper();
    int nk;
    logic [63:0] got;
    wr_bytes(8'hF8, 3, 64'h80E5AB, nk);
    hold(WR + 20);
    chk(wa == 8'hAB, "R12 wiper a", 64'(wa), 64'hAB);
    chk(wb == 7'h65, "R12 wiper b drops MSB", 64'(wb), 64'h65);
    chk(wc == 7'h00, "R12 wiper c drops MSB", 64'(wc), 0);
    rd_rand(8'hF8, 3, got);
    chk(got[23:0] == 24'h80E5AB, "R10 three byte sequential read", got, 64'h80E5AB);
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; a0 = 1'b1; wp = 1'b0;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    t_reset();
    t_addr();
    t_single_poll();
    t_page();
    t_current();
    t_abort();
    t_wrap();
    t_protect();
    t_wiper();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule